// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger

This block is the buffering and FIFO control stage of one serial channel in the style of the classic 16550. It has two byte queues, one for transmit and one for receive, and an 8-bit control byte that software can only write. The serial shifter, the baud generator, line status and interrupt identification sit outside the block. The shifter side pushes received bytes and pops bytes to transmit. The host side does the reverse.

The control byte has four jobs. It turns the queues on or off. It empties either queue on command. It picks one of four receive trigger levels. It selects the DMA signalling mode. The block raises a data-available interrupt when the receive occupancy equals the chosen level, but only while the external interrupt-enable input is high. With the queues switched off, each direction holds a single byte, and one stored byte is enough to raise the interrupt.

Top module: `sio_fifo_ctl`

## Requirements
- R1: After reset the control byte is zero. Both occupancy counts read 0, `dmaMode` is 0, both pop data outputs are 0 and the interrupt is low.
- R2: Bits [7:6] of the control byte are a trigger code: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. `rxDataIrq` is high exactly when `intEn` is high and `rxCount` equals the selected level. With code 3 and 15 bytes stored, the interrupt is low.
- R3: Bit [0] enables the queues. While it is 1, each queue holds up to 16 bytes. While it is 0, each queue holds at most 1 byte and the trigger level is 1.
- R4: A write whose bit [0] differs from the stored enable empties both queues at that clock edge. A write that leaves bit [0] unchanged keeps the queue contents.
- R5: A write with bit [2] set empties the transmit queue, and a write with bit [1] set empties the receive queue. Neither bit is stored, so a later write with the bit at 0 leaves the contents alone.
- R6: An empty command in the same cycle as a push wins, and the queue ends empty.
- R7: Bit [3] selects DMA mode. `dmaMode` is 1 only while bit [3] and the enable bit are both 1.
- R8: A push to a full queue is dropped and leaves the count unchanged.
- R9: Bytes pop in the order they were pushed. The pop data output updates on the clock edge of the pop. A pop from an empty queue changes neither the data output nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control byte write strobe |
| cfgWrData | input | 8 | Control byte value |
| intEn | input | 1 | External enable for the data-available interrupt |
| txPush | input | 1 | Push a byte into the transmit queue |
| txPushData | input | 8 | Byte to push into the transmit queue |
| txPop | input | 1 | Pop a byte from the transmit queue |
| txPopData | output | 8 | Last byte popped from the transmit queue |
| txCount | output | 5 | Transmit queue occupancy |
| rxPush | input | 1 | Push a byte into the receive queue |
| rxPushData | input | 8 | Byte to push into the receive queue |
| rxPop | input | 1 | Pop a byte from the receive queue |
| rxPopData | output | 8 | Last byte popped from the receive queue |
| rxCount | output | 5 | Receive queue occupancy |
| rxDataIrq | output | 1 | Receive data-available interrupt |
| dmaMode | output | 1 | DMA signalling mode (0 or 1) |

## Verification
The bench targets the trigger comparison at level 14 with 15 bytes stored. A design that used "at least" instead of "equal" would keep the interrupt high there. It pushes 17 bytes into a queue and pops one byte too many. A wrong design would overwrite data, wrap the count, or disturb the last popped byte. It writes an empty command together with a push, and it toggles the enable bit with data stored. Here a wrong design would leave a byte behind, keep the clear bits stored, or keep 16-byte capacity while the queues are off. It also sets the DMA bit while the queues are off, where a wrong design would report mode 1.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;
  // Control byte bit positions (software-visible layout)
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_RXCLR_BIT = 1;
  localparam int CFG_TXCLR_BIT = 2;
  localparam int CFG_DMA_BIT   = 3;
  localparam int CFG_TRIG_LSB  = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrTx;
    logic clrRx;
    logic oneByte;
  } fifo_strobe_t;
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       oneByte,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           popData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    capLimit;
  logic             full, empty, pushOk, popOk;

  assign capLimit = oneByte ? CW'(1) : CW'(DEPTH);
  assign full     = (count >= capLimit);
  assign empty    = (count == '0);
  assign pushOk   = push && !full;
  assign popOk    = pop && !empty;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      popData <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk) begin
        popData <= mem[rdPtr];
        rdPtr   <= nextPtr(rdPtr);
      end
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= capLimit);
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  assert_clear_beats_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && push) |=> (count == '0));
  assert_empty_pop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr) |=> ($stable(popData) && count <= CW'(1)));
endmodule

// File: rtl/sio_fifo_ctl_ctrl.sv
module sio_fifo_ctl_ctrl
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWrEn,
  input  logic [7:0]                 cfgWrData,
  input  logic                       intEn,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  output fifo_strobe_t               strobe,
  output logic                       rxDataIrq,
  output logic                       dmaMode
);
  localparam int CW = $clog2(DEPTH+1);

  logic [1:0]    trigCode;
  logic          dmaSel, fifoEn, enToggle;
  logic [CW-1:0] trigLevel;

  assign enToggle = cfgWrEn && (cfgWrData[CFG_EN_BIT] != fifoEn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigCode <= '0;
      dmaSel   <= 1'b0;
      fifoEn   <= 1'b0;
    end else if (cfgWrEn) begin
      trigCode <= cfgWrData[CFG_TRIG_LSB +: 2];
      dmaSel   <= cfgWrData[CFG_DMA_BIT];
      fifoEn   <= cfgWrData[CFG_EN_BIT];
    end
  end

  always_comb begin
    if (!fifoEn) trigLevel = CW'(1);
    else begin
      case (trigCode)
        2'd0:    trigLevel = CW'(LVL0);
        2'd1:    trigLevel = CW'(LVL1);
        2'd2:    trigLevel = CW'(LVL2);
        default: trigLevel = CW'(LVL3);
      endcase
    end
  end

  always_comb begin
    strobe.clrTx   = enToggle || (cfgWrEn && cfgWrData[CFG_TXCLR_BIT]);
    strobe.clrRx   = enToggle || (cfgWrEn && cfgWrData[CFG_RXCLR_BIT]);
    strobe.oneByte = !fifoEn;
  end

  assign rxDataIrq = intEn && (rxCount == trigLevel);
  assign dmaMode   = dmaSel && fifoEn;

  assert_irq_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rxDataIrq |-> (intEn && rxCount != '0));
  assert_dma_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !cfgWrData[CFG_EN_BIT]) |=> !dmaMode);
  assert_en_change_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgWrData[CFG_EN_BIT] != fifoEn) |=> (rxCount == '0));
endmodule

// File: rtl/sio_fifo_ctl_dp.sv
module sio_fifo_ctl_dp
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  fifo_strobe_t               strobe,
  input  logic                       txPush,
  input  logic [WIDTH-1:0]           txPushData,
  input  logic                       txPop,
  output logic [WIDTH-1:0]           txPopData,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic                       rxPush,
  input  logic [WIDTH-1:0]           rxPushData,
  input  logic                       rxPop,
  output logic [WIDTH-1:0]           rxPopData,
  output logic [$clog2(DEPTH+1)-1:0] rxCount
);
  sio_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(strobe.clrTx), .oneByte(strobe.oneByte),
    .push(txPush), .pushData(txPushData), .pop(txPop),
    .popData(txPopData), .count(txCount)
  );

  sio_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(strobe.clrRx), .oneByte(strobe.oneByte),
    .push(rxPush), .pushData(rxPushData), .pop(rxPop),
    .popData(rxPopData), .count(rxCount)
  );
endmodule

// File: rtl/sio_fifo_ctl.sv
module sio_fifo_ctl
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWrEn,
  input  logic [7:0]                 cfgWrData,
  input  logic                       intEn,
  input  logic                       txPush,
  input  logic [WIDTH-1:0]           txPushData,
  input  logic                       txPop,
  output logic [WIDTH-1:0]           txPopData,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic                       rxPush,
  input  logic [WIDTH-1:0]           rxPushData,
  input  logic                       rxPop,
  output logic [WIDTH-1:0]           rxPopData,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic                       rxDataIrq,
  output logic                       dmaMode
);
  fifo_strobe_t strobe;

  sio_fifo_ctl_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .intEn(intEn), .rxCount(rxCount), .strobe(strobe),
    .rxDataIrq(rxDataIrq), .dmaMode(dmaMode)
  );

  sio_fifo_ctl_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop),
    .txPopData(txPopData), .txCount(txCount),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxCount(rxCount)
  );
endmodule

// File: tb/sio_fifo_ctl_tb.sv
`timescale 1ns/1ps
module sio_fifo_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0, intEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txPushData = '0, rxPushData = '0, txPopData, rxPopData;
  logic [4:0] txCount, rxCount;
  logic rxDataIrq, dmaMode;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sio_fifo_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .intEn(intEn), .txPush(txPush), .txPushData(txPushData), .txPop(txPop),
    .txPopData(txPopData), .txCount(txCount), .rxPush(rxPush),
    .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .rxCount(rxCount), .rxDataIrq(rxDataIrq), .dmaMode(dmaMode)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wdata;
    logic       txP;
    logic       rxP;
    logic       ie;
    logic [4:0] expTx;
    logic [4:0] expRx;
    logic       expIrq;
    logic       expDma;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0}, // R2 empty
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd1, 1'b1, 1'b0}, // R3 single byte, level 1
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd1, 1'b1, 1'b0}, // R3 second byte dropped
    '{1'b1, 8'h08, 1'b0, 1'b0, 1'b1, 5'd0, 5'd1, 1'b1, 1'b0}, // R7 dma off while disabled
    '{1'b1, 8'h49, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b1}, // R4 enable change clears
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd1, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd2, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd3, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd4, 1'b1, 1'b1}, // R2 level 4
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b1}, // R2 gated by intEn
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd0, 5'd5, 1'b0, 1'b1}, // R2 past level
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 5'd1, 5'd5, 1'b0, 1'b1},
    '{1'b1, 8'h4D, 1'b0, 1'b0, 1'b1, 5'd0, 5'd5, 1'b0, 1'b1}, // R5 tx only
    '{1'b1, 8'h49, 1'b0, 1'b0, 1'b1, 5'd0, 5'd5, 1'b0, 1'b1}, // R5 not stored
    '{1'b1, 8'h4B, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b1}, // R5 rx only
    '{1'b1, 8'h41, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0}  // R7 dma bit cleared
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cfgWrEn = 1'b0; txPush = 1'b0; rxPush = 1'b0; txPop = 1'b0; rxPop = 1'b0;
  endtask

  task automatic wrCfg(input logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    step();
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1'b1; rxPushData = d;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    intEn = 1'b1;
    #1;
    // R1 reset state
    check("R1 txCount", int'(txCount), 0);
    check("R1 rxCount", int'(rxCount), 0);
    check("R1 dmaMode", int'(dmaMode), 0);
    check("R1 rxDataIrq", int'(rxDataIrq), 0);
    check("R1 rxPopData", int'(rxPopData), 0);
    check("R1 txPopData", int'(txPopData), 0);
    rst_n = 1'b1;
    step();

    // Table walk
    for (int i = 0; i < NV; i++) begin
      cfgWrEn = TBL[i].wr; cfgWrData = TBL[i].wdata;
      txPush = TBL[i].txP; rxPush = TBL[i].rxP; intEn = TBL[i].ie;
      txPushData = 8'(i); rxPushData = 8'(i);
      step();
      check($sformatf("row %0d txCount (R3,R4,R5)", i), int'(txCount), int'(TBL[i].expTx));
      check($sformatf("row %0d rxCount (R3,R4,R5)", i), int'(rxCount), int'(TBL[i].expRx));
      check($sformatf("row %0d irq (R2)", i), int'(rxDataIrq), int'(TBL[i].expIrq));
      check($sformatf("row %0d dma (R7)", i), int'(dmaMode), int'(TBL[i].expDma));
    end
    intEn = 1'b1;

    // R8 / R9: fill transmit past capacity, drain, pop once more
    for (int i = 0; i < 17; i++) begin
      txPush = 1'b1; txPushData = 8'(8'h10 + i);
      step();
    end
    check("R8 full count", int'(txCount), 16);
    for (int i = 0; i < 16; i++) begin
      txPop = 1'b1;
      step();
      check($sformatf("R9 order byte %0d", i), int'(txPopData), 8'h10 + i);
    end
    check("R8 drained count", int'(txCount), 0);
    txPop = 1'b1;
    step();
    check("R9 empty pop data", int'(txPopData), 8'h1F);
    check("R9 empty pop count", int'(txCount), 0);

    // R2 level 14 with equality only
    wrCfg(8'hC1);
    for (int i = 0; i < 13; i++) pushRx(8'(i));
    check("R2 code3 at 13", int'(rxDataIrq), 0);
    pushRx(8'hAA);
    check("R2 code3 at 14", int'(rxDataIrq), 1);
    pushRx(8'hBB);
    check("R2 code3 at 15", int'(rxDataIrq), 0);
    wrCfg(8'h81);
    check("R4 same enable keeps data", int'(rxCount), 15);
    check("R2 code2 at 15", int'(rxDataIrq), 0);
    wrCfg(8'h83);
    for (int i = 0; i < 8; i++) pushRx(8'(i));
    check("R2 code2 at 8", int'(rxDataIrq), 1);

    // R6 clear beats push
    cfgWrEn = 1'b1; cfgWrData = 8'h83; rxPush = 1'b1; rxPushData = 8'h55;
    step();
    check("R6 rx clear with push", int'(rxCount), 0);
    txPush = 1'b1; txPushData = 8'h01;
    step();
    cfgWrEn = 1'b1; cfgWrData = 8'h85; txPush = 1'b1; txPushData = 8'h66;
    step();
    check("R6 tx clear with push", int'(txCount), 0);

    // R4 disable with data, then R3 single-byte holding
    pushRx(8'h01); pushRx(8'h02); pushRx(8'h03);
    txPush = 1'b1; txPushData = 8'h09;
    step();
    wrCfg(8'h00);
    check("R4 disable clears rx", int'(rxCount), 0);
    check("R4 disable clears tx", int'(txCount), 0);
    pushRx(8'hA5);
    pushRx(8'h5A);
    check("R3 holds one byte", int'(rxCount), 1);
    check("R3 irq at one byte", int'(rxDataIrq), 1);
    rxPop = 1'b1;
    step();
    check("R3 holding byte data", int'(rxPopData), 8'hA5);
    check("R3 holding byte empty", int'(rxCount), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule